// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block is the trap-entry stage of a simple in-order core. Each cycle it looks at three kinds of request: a debug request, a synchronous exception (with a cause code and, optionally, a faulting virtual address), and an interrupt whose level has already been chosen by a separate prioritizer. It accepts at most one of them. It then updates the architectural trap state: the per-level saved-PC registers, the per-level saved-status registers, the cause register, the faulting-address register, the double-exception PC register, the debug cause register and the processor status word. One cycle after the request it drives the handler address on `redirect_pc` together with a single-cycle `taken` pulse.

The handler address is chosen from the status bits. A general exception goes to the user or the kernel vector, or to the double-exception vector if the core is already in exception mode. A high-level interrupt goes to the vector for its own level. A debug entry goes to the debug vector. Every vector is a fixed offset from a vector base register that the core can rewrite at run time. The pipeline can write the status word directly, for example on a return from a handler. Saved-PC and saved-status registers are read through a level-indexed port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A general exception taken while the exception-mode bit is clear stores `req_pc` in the level-1 saved-PC register. It selects the user vector (offset 0x340) when the user-mode bit is set and the kernel vector (offset 0x300) otherwise.
- R2: A general exception taken while the exception-mode bit is set selects the double-exception vector (offset 0x3C0). It stores `req_pc` in the double-exception PC register when that register is configured, or in the level-1 saved-PC register when it is not. In the configured case the level-1 saved-PC register keeps its value.
- R3: Every general exception writes its cause code into the cause register and sets the exception-mode bit. It leaves the user-mode bit and the interrupt-level field unchanged. Status layout: bits 3:0 hold the interrupt level, bit 4 the exception-mode bit and bit 5 the user-mode bit.
- R4: The faulting-address register is loaded with `exc_addr` only when an accepted exception has `exc_has_addr` set. Any other cycle leaves it unchanged.
- R5: An accepted level-1 interrupt behaves as a general exception (R1 to R3) with cause code 4.
- R6: An accepted interrupt of level L with 2 ≤ L saves `req_pc` in the level-L saved-PC register and the full status word in the level-L saved-status register. It then sets the interrupt-level field to L and sets exception mode, keeping the user-mode bit. It redirects to offset 0x100 + 0x20·L.
- R7: An accepted debug request writes `dbg_cause` into the debug cause register and saves `req_pc` and the status word in the registers of the debug level D. It then sets the interrupt level to D and sets exception mode, and redirects to offset 0x200.
- R8: With relocation enabled, the handler address is the vector base register plus the vector offset. The vector base register resets to the default base and is loaded from `vbase_wdata` when `vbase_we` is high.
- R9: An interrupt is accepted only when 1 ≤ L ≤ NLEVEL and L is greater than the current interrupt level. Otherwise it is ignored: no pulse and no state change.
- R10: A debug request is accepted only when the current interrupt level is below D. Otherwise it is ignored.
- R11: When several requests are present in one cycle, debug wins over an exception and an exception wins over an interrupt. The losers leave no trace in the state.
- R12: `taken` and `redirect_pc` are registered and appear in the cycle after the request. `taken` is high for one cycle per accepted request. After reset `taken` is 0, the status word is 0x10 and the vector base equals the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | CAUSE_W | Exception cause code |
| exc_has_addr | input | 1 | Exception carries a faulting address |
| exc_addr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug entry request |
| dbg_cause | input | CAUSE_W | Debug cause code |
| irq_req | input | 1 | Interrupt request at `irq_level` |
| irq_level | input | 4 | Level of the interrupt from the prioritizer |
| req_pc | input | XLEN | PC to save for the request |
| ps_we | input | 1 | Status word write enable |
| ps_wdata | input | 6 | Status word write data |
| vbase_we | input | 1 | Vector base write enable |
| vbase_wdata | input | XLEN | Vector base write data |
| rd_lvl | input | 4 | Level selector for the saved-state read port |
| redirect_pc | output | XLEN | Handler address |
| taken | output | 1 | One-cycle entry pulse |
| ps_o | output | 6 | Current status word |
| vbase_o | output | XLEN | Current vector base |
| cause_o | output | CAUSE_W | Cause register |
| vaddr_o | output | XLEN | Faulting-address register |
| depc_o | output | XLEN | Double-exception PC register |
| dbg_cause_o | output | CAUSE_W | Debug cause register |
| rd_epc | output | XLEN | Saved PC of level `rd_lvl` (0 if none) |
| rd_eps | output | 6 | Saved status of level `rd_lvl` (0 if none) |

## Verification
A wrong status word is the most damaging fault here. It shows at the ports on the very next request, because the handler address and the choice of save register follow from the exception-mode, user-mode and level bits: a kernel entry lands on the double vector, or a blocked interrupt still pulses `taken`. A wrong save or a misrouted write stays hidden until the level-indexed read port or the cause and address outputs are sampled. For that reason every entry is followed by reading the affected saved registers, and also the ones that must not have moved. Priority faults show in the same cycle as the redirect: the wrong vector appears, or cause registers change that should have stayed put.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int PS_W  = 6;
    localparam int LVL_W = 4;
    localparam int OFS_W = 12;

    // Status word: [3:0] interrupt level, [4] exception mode, [5] user mode
    typedef struct packed {
        logic             um;
        logic             excm;
        logic [LVL_W-1:0] intlevel;
    } ps_t;

    typedef enum logic [2:0] {
        ENT_NONE,
        ENT_DEBUG,
        ENT_EXC,
        ENT_IRQ_L1,
        ENT_IRQ_HI
    } entry_e;

    typedef enum logic [2:0] {
        VEC_KERNEL,
        VEC_USER,
        VEC_DOUBLE,
        VEC_LEVEL,
        VEC_DEBUG
    } vec_e;

    localparam ps_t PS_RESET = '{um: 1'b0, excm: 1'b1, intlevel: '0};
    localparam int  LVL1_IRQ_CAUSE = 4;

    // Offset of each handler from the vector base
    function automatic logic [OFS_W-1:0] vec_offset(vec_e kind, logic [LVL_W-1:0] lvl);
        logic [OFS_W-1:0] ofs;
        case (kind)
            VEC_KERNEL: ofs = 12'h300;
            VEC_USER:   ofs = 12'h340;
            VEC_DOUBLE: ofs = 12'h3C0;
            VEC_DEBUG:  ofs = 12'h200;
            default:    ofs = 12'h100 + {3'b000, lvl, 5'b00000};
        endcase
        return ofs;
    endfunction

endpackage

// File: rtl/exc_entry_sel.sv
module exc_entry_sel
    import exc_entry_pkg::*;
#(
    parameter int NLEVEL    = 6,
    parameter int DBG_LEVEL = 6
) (
    input  ps_t              ps,
    input  logic             dbg_req,
    input  logic             exc_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    output entry_e           kind,
    output vec_e             vkind,
    output logic [LVL_W-1:0] lvl
);
    localparam logic [LVL_W-1:0] DBG_L = LVL_W'(DBG_LEVEL);
    localparam logic [LVL_W-1:0] MAX_L = LVL_W'(NLEVEL);

    logic dbg_ok, irq_ok;
    vec_e gen_vec;

    assign dbg_ok  = dbg_req && (ps.intlevel < DBG_L);
    assign irq_ok  = irq_req && (irq_level != '0) && (irq_level <= MAX_L)
                     && (irq_level > ps.intlevel);
    assign gen_vec = ps.excm ? VEC_DOUBLE : (ps.um ? VEC_USER : VEC_KERNEL);

    always_comb begin
        kind  = ENT_NONE;
        vkind = VEC_KERNEL;
        lvl   = LVL_W'(1);
        if (dbg_ok) begin
            kind  = ENT_DEBUG;
            vkind = VEC_DEBUG;
            lvl   = DBG_L;
        end else if (exc_req) begin
            kind  = ENT_EXC;
            vkind = gen_vec;
        end else if (irq_ok) begin
            if (irq_level == LVL_W'(1)) begin
                kind  = ENT_IRQ_L1;
                vkind = gen_vec;
            end else begin
                kind  = ENT_IRQ_HI;
                vkind = VEC_LEVEL;
                lvl   = irq_level;
            end
        end
    end
endmodule

// File: rtl/exc_entry_vec.sv
module exc_entry_vec
    import exc_entry_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter bit          RELOC     = 1'b1,
    parameter logic [31:0] DEF_VBASE = 32'h4000_0000
) (
    input  vec_e             vkind,
    input  logic [LVL_W-1:0] lvl,
    input  logic [XLEN-1:0]  vbase,
    output logic [XLEN-1:0]  target
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] ofs;

    assign ofs = XLEN'(vec_offset(vkind, lvl));

    generate
        if (RELOC) begin : g_reloc
            assign base = vbase;
        end else begin : g_fixed
            logic unused_base;
            assign unused_base = ^vbase;
            assign base = XLEN'(DEF_VBASE);
        end
    endgenerate

    assign target = base + ofs;
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
    import exc_entry_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          CAUSE_W   = 6,
    parameter int          NLEVEL    = 6,
    parameter bit          HAS_DEPC  = 1'b1,
    parameter logic [31:0] DEF_VBASE = 32'h4000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  entry_e             kind,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [XLEN-1:0]    pc,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               exc_has_addr,
    input  logic [XLEN-1:0]    exc_addr,
    input  logic [CAUSE_W-1:0] dbg_cause,
    input  logic               ps_we,
    input  ps_t                ps_wdata,
    input  logic               vbase_we,
    input  logic [XLEN-1:0]    vbase_wdata,
    input  logic [LVL_W-1:0]   rd_lvl,
    output ps_t                ps_q,
    output logic [XLEN-1:0]    vbase_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    vaddr_q,
    output logic [XLEN-1:0]    depc_q,
    output logic [CAUSE_W-1:0] dbgcause_q,
    output logic [XLEN-1:0]    rd_epc,
    output ps_t                rd_eps
);
    logic [XLEN-1:0] epc_q [1:NLEVEL];
    ps_t             eps_q [2:NLEVEL];

    logic gen_ent, lvl_ent;
    assign gen_ent = (kind == ENT_EXC) || (kind == ENT_IRQ_L1);
    assign lvl_ent = (kind == ENT_DEBUG) || (kind == ENT_IRQ_HI);

    // Status word
    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= PS_RESET;
        end else if (gen_ent) begin
            ps_q.excm <= 1'b1;
        end else if (lvl_ent) begin
            ps_q.excm     <= 1'b1;
            ps_q.intlevel <= lvl;
        end else if (ps_we) begin
            ps_q <= ps_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vbase_q    <= XLEN'(DEF_VBASE);
            cause_q    <= '0;
            vaddr_q    <= '0;
            dbgcause_q <= '0;
        end else begin
            if (vbase_we) vbase_q <= vbase_wdata;
            if (gen_ent)
                cause_q <= (kind == ENT_IRQ_L1) ? CAUSE_W'(LVL1_IRQ_CAUSE) : exc_cause;
            if (kind == ENT_EXC && exc_has_addr) vaddr_q <= exc_addr;
            if (kind == ENT_DEBUG) dbgcause_q <= dbg_cause;
        end
    end

    generate
        if (HAS_DEPC) begin : g_depc
            always_ff @(posedge clk) begin
                if (rst) depc_q <= '0;
                else if (gen_ent && ps_q.excm) depc_q <= pc;
            end
        end else begin : g_no_depc
            assign depc_q = '0;
        end

        for (genvar g = 1; g <= NLEVEL; g++) begin : g_epc
            logic wr;
            if (g == 1) begin : g_l1
                assign wr = gen_ent && (!ps_q.excm || !HAS_DEPC);
            end else begin : g_hi
                assign wr = lvl_ent && (lvl == LVL_W'(g));
            end
            always_ff @(posedge clk) begin
                if (rst) epc_q[g] <= '0;
                else if (wr) epc_q[g] <= pc;
            end
        end

        for (genvar g = 2; g <= NLEVEL; g++) begin : g_eps
            always_ff @(posedge clk) begin
                if (rst) eps_q[g] <= '0;
                else if (lvl_ent && (lvl == LVL_W'(g))) eps_q[g] <= ps_q;
            end
        end
    endgenerate

    always_comb begin
        rd_epc = '0;
        rd_eps = '0;
        for (int i = 1; i <= NLEVEL; i++)
            if (rd_lvl == LVL_W'(i)) rd_epc = epc_q[i];
        for (int i = 2; i <= NLEVEL; i++)
            if (rd_lvl == LVL_W'(i)) rd_eps = eps_q[i];
    end

    // R6
    irq_hi_level_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == ENT_IRQ_HI) |=> (ps_q.excm && ps_q.intlevel == $past(lvl)));

    // R3
    gen_keeps_level_chk: assert property (@(posedge clk) disable iff (rst)
        gen_ent |=> (ps_q.excm && ps_q.intlevel == $past(ps_q.intlevel)
                     && ps_q.um == $past(ps_q.um)));

    // R4
    vaddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(kind == ENT_EXC && exc_has_addr) |=> $stable(vaddr_q));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          CAUSE_W   = 6,
    parameter int          NLEVEL    = 6,
    parameter int          DBG_LEVEL = 6,
    parameter bit          HAS_DEPC  = 1'b1,
    parameter bit          RELOC     = 1'b1,
    parameter logic [31:0] DEF_VBASE = 32'h4000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               exc_has_addr,
    input  logic [XLEN-1:0]    exc_addr,
    input  logic               dbg_req,
    input  logic [CAUSE_W-1:0] dbg_cause,
    input  logic               irq_req,
    input  logic [3:0]         irq_level,
    input  logic [XLEN-1:0]    req_pc,
    input  logic               ps_we,
    input  logic [5:0]         ps_wdata,
    input  logic               vbase_we,
    input  logic [XLEN-1:0]    vbase_wdata,
    input  logic [3:0]         rd_lvl,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               taken,
    output logic [5:0]         ps_o,
    output logic [XLEN-1:0]    vbase_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [XLEN-1:0]    vaddr_o,
    output logic [XLEN-1:0]    depc_o,
    output logic [CAUSE_W-1:0] dbg_cause_o,
    output logic [XLEN-1:0]    rd_epc,
    output logic [5:0]         rd_eps
);
    localparam logic [LVL_W-1:0] DBG_L = LVL_W'(DBG_LEVEL);

    ps_t              ps_cur, eps_rd;
    entry_e           kind;
    vec_e             vkind;
    logic [LVL_W-1:0] lvl;
    logic [XLEN-1:0]  target;

    exc_entry_sel #(.NLEVEL(NLEVEL), .DBG_LEVEL(DBG_LEVEL)) u_sel (
        .ps(ps_cur), .dbg_req(dbg_req), .exc_req(exc_req), .irq_req(irq_req),
        .irq_level(irq_level), .kind(kind), .vkind(vkind), .lvl(lvl)
    );

    exc_entry_vec #(.XLEN(XLEN), .RELOC(RELOC), .DEF_VBASE(DEF_VBASE)) u_vec (
        .vkind(vkind), .lvl(lvl), .vbase(vbase_o), .target(target)
    );

    exc_entry_regs #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .NLEVEL(NLEVEL),
        .HAS_DEPC(HAS_DEPC), .DEF_VBASE(DEF_VBASE)
    ) u_regs (
        .clk(clk), .rst(rst), .kind(kind), .lvl(lvl), .pc(req_pc),
        .exc_cause(exc_cause), .exc_has_addr(exc_has_addr), .exc_addr(exc_addr),
        .dbg_cause(dbg_cause), .ps_we(ps_we), .ps_wdata(ps_t'(ps_wdata)),
        .vbase_we(vbase_we), .vbase_wdata(vbase_wdata), .rd_lvl(rd_lvl),
        .ps_q(ps_cur), .vbase_q(vbase_o), .cause_q(cause_o), .vaddr_q(vaddr_o),
        .depc_q(depc_o), .dbgcause_q(dbg_cause_o), .rd_epc(rd_epc), .rd_eps(eps_rd)
    );

    assign ps_o   = ps_cur;
    assign rd_eps = eps_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_pc <= '0;
            taken       <= 1'b0;
        end else begin
            taken <= (kind != ENT_NONE);
            if (kind != ENT_NONE) redirect_pc <= target;
        end
    end

    // R12
    exc_always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> taken);

    // R10
    dbg_block_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !exc_req && !irq_req && ps_cur.intlevel >= DBG_L) |=> !taken);
endmodule

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 0, exc_has_addr = 0, dbg_req = 0, irq_req = 0;
    logic [5:0]  exc_cause = 0, dbg_cause = 0, ps_wdata = 0;
    logic [31:0] exc_addr = 0, req_pc = 0, vbase_wdata = 0;
    logic [3:0]  irq_level = 0, rd_lvl = 0;
    logic        ps_we = 0, vbase_we = 0;
    logic [31:0] redirect_pc, vbase_o, vaddr_o, depc_o, rd_epc;
    logic        taken;
    logic [5:0]  ps_o, cause_o, dbg_cause_o, rd_eps;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_has_addr(exc_has_addr), .exc_addr(exc_addr), .dbg_req(dbg_req),
        .dbg_cause(dbg_cause), .irq_req(irq_req), .irq_level(irq_level),
        .req_pc(req_pc), .ps_we(ps_we), .ps_wdata(ps_wdata), .vbase_we(vbase_we),
        .vbase_wdata(vbase_wdata), .rd_lvl(rd_lvl), .redirect_pc(redirect_pc),
        .taken(taken), .ps_o(ps_o), .vbase_o(vbase_o), .cause_o(cause_o),
        .vaddr_o(vaddr_o), .depc_o(depc_o), .dbg_cause_o(dbg_cause_o),
        .rd_epc(rd_epc), .rd_eps(rd_eps)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every taken pulse must match the next expected redirect (R12)
    always @(negedge clk) begin
        if (!rst && taken) begin
            if (exp_q.size() == 0) begin
                check("R9/R10/R12 spurious taken", 32'(taken), 32'h0);
            end else begin
                check("R12 redirect", redirect_pc, exp_q.pop_front());
            end
        end
    end

    task automatic fire(input logic d, input logic e, input logic i, input logic [3:0] lv,
                        input logic [31:0] pc, input logic [5:0] ec, input logic [5:0] dc,
                        input logic ha, input logic [31:0] addr,
                        input bit expect_t, input logic [31:0] exp_pc);
        @(negedge clk);
        dbg_req = d; exc_req = e; irq_req = i; irq_level = lv; req_pc = pc;
        exc_cause = ec; dbg_cause = dc; exc_has_addr = ha; exc_addr = addr;
        if (expect_t) exp_q.push_back(exp_pc);
        @(negedge clk);
        dbg_req = 0; exc_req = 0; irq_req = 0; exc_has_addr = 0;
    endtask

    task automatic write_ps(input logic [5:0] v);
        @(negedge clk); ps_we = 1; ps_wdata = v;
        @(negedge clk); ps_we = 0;
    endtask

    task automatic read_lvl(input logic [3:0] l, input logic [31:0] epc_e,
                            input logic [5:0] eps_e, input string req);
        rd_lvl = l;
        #1;
        check(req, rd_epc, epc_e);
        check(req, 32'(rd_eps), 32'(eps_e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R12 reset state
        check("R12 taken reset", 32'(taken), 32'h0);
        check("R12 ps reset", 32'(ps_o), 32'h10);
        check("R8 vbase reset", vbase_o, 32'h4000_0000);

        // R1 / R3 kernel entry
        write_ps(6'h00);
        fire(0, 1, 0, 0, 32'h1000, 6'd5, 0, 0, 0, 1, 32'h4000_0300);
        check("R3 cause", 32'(cause_o), 32'd5);
        check("R3 excm set", 32'(ps_o), 32'h10);
        read_lvl(1, 32'h1000, 6'h00, "R1 epc1");

        // R2 double exception
        fire(0, 1, 0, 0, 32'h2000, 6'd7, 0, 0, 0, 1, 32'h4000_03C0);
        check("R2 depc", depc_o, 32'h2000);
        read_lvl(1, 32'h1000, 6'h00, "R2 epc1 kept");
        check("R4 vaddr untouched", vaddr_o, 32'h0);

        // R1 / R4 user entry with address
        write_ps(6'h20);
        fire(0, 1, 0, 0, 32'h3000, 6'd9, 0, 1, 32'hDEAD_BEEF, 1, 32'h4000_0340);
        check("R4 vaddr", vaddr_o, 32'hDEAD_BEEF);
        check("R3 um kept", 32'(ps_o), 32'h30);
        read_lvl(1, 32'h3000, 6'h00, "R1 epc1 user");

        // R8 relocation, R5 level-1 interrupt
        @(negedge clk); vbase_we = 1; vbase_wdata = 32'h8000_0000;
        @(negedge clk); vbase_we = 0;
        check("R8 vbase write", vbase_o, 32'h8000_0000);
        write_ps(6'h00);
        fire(0, 0, 1, 1, 32'h4000, 0, 0, 0, 0, 1, 32'h8000_0300);
        check("R5 cause 4", 32'(cause_o), 32'd4);
        read_lvl(1, 32'h4000, 6'h00, "R5 epc1");

        // R6 level-3 interrupt
        write_ps(6'h02);
        fire(0, 0, 1, 3, 32'h5000, 0, 0, 0, 0, 1, 32'h8000_0160);
        check("R6 ps", 32'(ps_o), 32'h13);
        read_lvl(3, 32'h5000, 6'h02, "R6 level3 save");

        // R9 blocked interrupts
        fire(0, 0, 1, 2, 32'h5100, 0, 0, 0, 0, 0, 0);
        check("R9 ps unchanged", 32'(ps_o), 32'h13);
        read_lvl(2, 32'h0, 6'h00, "R9 level2 untouched");
        write_ps(6'h00);
        fire(0, 0, 1, 7, 32'h5200, 0, 0, 0, 0, 0, 0);
        check("R9 level above max", 32'(ps_o), 32'h00);

        // R7 debug entry
        write_ps(6'h13);
        fire(1, 0, 0, 0, 32'h6000, 0, 6'h21, 0, 0, 1, 32'h8000_0200);
        check("R7 dbg cause", 32'(dbg_cause_o), 32'h21);
        check("R7 ps", 32'(ps_o), 32'h16);
        read_lvl(6, 32'h6000, 6'h13, "R7 level6 save");

        // R10 blocked debug
        fire(1, 0, 0, 0, 32'h6100, 0, 6'h22, 0, 0, 0, 0);
        check("R10 dbg cause kept", 32'(dbg_cause_o), 32'h21);
        read_lvl(6, 32'h6000, 6'h13, "R10 level6 kept");

        // R11 debug over exception and interrupt
        write_ps(6'h00);
        fire(1, 1, 1, 2, 32'h7000, 6'd11, 6'h05, 1, 32'h1234_5678, 1, 32'h8000_0200);
        check("R11 cause kept", 32'(cause_o), 32'd4);
        check("R11 vaddr kept", vaddr_o, 32'hDEAD_BEEF);
        read_lvl(6, 32'h7000, 6'h00, "R11 debug saved");

        // R11 exception over interrupt
        write_ps(6'h00);
        fire(0, 1, 1, 2, 32'h7100, 6'd12, 0, 0, 0, 1, 32'h8000_0300);
        check("R11 exc cause", 32'(cause_o), 32'd12);
        read_lvl(2, 32'h0, 6'h00, "R11 level2 untouched");

        @(negedge clk);
        check("R12 single pulse", 32'(taken), 32'h0);
        check("R12 queue drained", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule